// File: doc/BRIEF.md
# Chainable Priority Encoder (8-input slice, 16-input build)

The block turns a set of active-low request lines into the binary index of the most urgent one. A slice serves eight requests. Line 7 is the most urgent and line 0 the least. The slice drives the inverted index of the winning request on a three-bit active-low code. It has an active-low enable. A group flag goes low when the slice is enabled and sees at least one request. A chain output goes low only when the slice is enabled and every request is idle.

The top level joins two slices into a sixteen-request encoder. The upper slice takes requests 15..8 and the lower slice takes requests 7..0. The chain output of the upper slice drives the enable of the lower slice, so the lower half is heard only when the upper half is quiet. The top code bit is the upper slice's group flag. Each lower code bit is the AND of the matching active-low code bits of the two slices. The combined group flag is the AND of both group flags. The lower slice's chain output is brought out so that a further stage can be attached. The whole path is combinational.

Top module: `prio16_chain`

## Requirements
- R1: With a slice enabled and at least one request low, its code equals the bitwise inverse of the highest-numbered low request (request 5 alone gives code 3'b010).
- R2: With a slice's enable high, its code is 3'b111, its group flag is 1 and its chain output is 1, whatever the requests are.
- R3: A slice's group flag is 0 exactly when the slice is enabled and one or more of its requests are low.
- R4: A slice's chain output is 0 exactly when the slice is enabled and none of its requests is low.
- R5: With the top enabled and at least one of the sixteen requests low, `code_n` equals the bitwise inverse of the highest-numbered low request (request 9 gives 4'b0110).
- R6: A low request among lines 15..8 masks every request on lines 7..0. Changing the lower requests then leaves `code_n`, `grp_n` and `en_out_n` unchanged.
- R7: `code_n[3]` is 0 exactly when the top is enabled and a request among lines 15..8 is low.
- R8: `grp_n` is 0 exactly when the top is enabled and any of the sixteen requests is low.
- R9: With `en_n` high, `code_n` is 4'b1111, `grp_n` is 1 and `en_out_n` is 1.
- R10: With the top enabled and no request low, `code_n` is 4'b1111, `grp_n` is 1 and `en_out_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| en_n | input | 1 | Active-low enable of the whole encoder |
| req_n | input | 16 | Active-low requests; bit 15 is the most urgent |
| code_n | output | 4 | Active-low index of the winning request |
| grp_n | output | 1 | Low when enabled and any request is low |
| en_out_n | output | 1 | Low when enabled and no request is low; feeds a further stage |

## Verification
Whenever the inputs change, the assertions check several properties. A disabled slice is fully quiet. The group flag and the chain output of a slice are never low together. A low group flag means the request named by the code really is low. The top code bit follows the upper group flag, and an active upper half turns the lower slice off. The bench scenarios are needed for the rest: that the chosen index is the highest one, the exact code values at the ends of each half, and that lower requests have no effect while an upper request is low. These cannot be read from a single relation between signals.

// File: rtl/prio16_chain.sv
module prio8_slice #(
  parameter int N = 8
) (
  input  logic                 en_in_n,
  input  logic [N-1:0]         req_n,
  output logic [$clog2(N)-1:0] code_n,
  output logic                 grp_n,
  output logic                 en_out_n
);
  localparam int W = $clog2(N);

  logic [W-1:0] idx;
  logic         any;

  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!req_n[i]) begin
        idx = W'(i);
        any = 1'b1;
      end
    end
  end

  assign code_n   = (!en_in_n && any) ? ~idx : '1;
  assign grp_n    = !(!en_in_n && any);
  assign en_out_n = !(!en_in_n && !any);

  always_comb begin
    if (en_in_n) begin
      p_off_quiet_r2: assert (code_n == '1 && grp_n && en_out_n)
        else $error("disabled slice drives an output low");
    end
    p_flags_excl_r3: assert (grp_n || en_out_n)
      else $error("group and chain both low (R3/R4)");
    if (!grp_n) begin
      p_code_valid_r1: assert (req_n[~code_n] == 1'b0)
        else $error("code names an idle request");
    end
  end
endmodule

module prio16_chain (
  input  logic        en_n,
  input  logic [15:0] req_n,
  output logic [3:0]  code_n,
  output logic        grp_n,
  output logic        en_out_n
);
  localparam int HALF = 8;
  localparam int CW   = $clog2(HALF);

  logic [CW-1:0] hi_code_n, lo_code_n;
  logic          hi_grp_n, lo_grp_n, hi_chain_n;

  prio8_slice #(.N(HALF)) u_hi (
    .en_in_n (en_n),
    .req_n   (req_n[2*HALF-1:HALF]),
    .code_n  (hi_code_n),
    .grp_n   (hi_grp_n),
    .en_out_n(hi_chain_n)
  );

  prio8_slice #(.N(HALF)) u_lo (
    .en_in_n (hi_chain_n),
    .req_n   (req_n[HALF-1:0]),
    .code_n  (lo_code_n),
    .grp_n   (lo_grp_n),
    .en_out_n(en_out_n)
  );

  assign code_n = {hi_grp_n, hi_code_n & lo_code_n};
  assign grp_n  = hi_grp_n & lo_grp_n;

  always_comb begin
    p_top_bit_r7: assert (code_n[3] == !(!en_n && (req_n[15:8] != 8'hFF)))
      else $error("top code bit disagrees with upper requests");
    if (!hi_grp_n) begin
      p_mask_lower_r6: assert (lo_grp_n && lo_code_n == '1 && en_out_n)
        else $error("lower slice active while upper request present");
    end
    p_group_r8: assert (grp_n == !(!en_n && (req_n != 16'hFFFF)))
      else $error("combined group flag wrong");
    if (en_n) begin
      p_off_r9: assert (code_n == 4'hF && grp_n && en_out_n)
        else $error("disabled encoder drives an output low");
    end
  end
endmodule

// File: tb/prio16_chain_test.sv
module prio16_chain_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        en_n;
  logic [15:0] req_n;
  logic [3:0]  code_n;
  logic        grp_n, en_out_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  prio16_chain uut (
    .en_n(en_n), .req_n(req_n), .code_n(code_n),
    .grp_n(grp_n), .en_out_n(en_out_n)
  );

  function automatic logic [5:0] model(input logic e, input logic [15:0] r);
    logic [3:0] c;
    logic any;
    c = 4'hF; any = 1'b0;
    for (int i = 0; i < 16; i++)
      if (!r[i]) begin c = ~4'(i); any = 1'b1; end
    if (e) return 6'b111111;
    if (!any) return {4'hF, 1'b1, 1'b0};
    return {c, 1'b0, 1'b1};
  endfunction

  task automatic apply(input logic e, input logic [15:0] r, input string tag);
    logic [5:0] exp;
    en_n = e; req_n = r;
    @(negedge clk);
    exp = model(e, r);
    checks++;
    if ({code_n, grp_n, en_out_n} !== exp) begin
      fails++;
      $display("FAIL %s en_n=%b req_n=%h: got code=%b grp=%b eo=%b, expected code=%b grp=%b eo=%b",
               tag, e, r, code_n, grp_n, en_out_n, exp[5:2], exp[1], exp[0]);
    end
  endtask

  task automatic same_out(input logic [15:0] r1, input logic [15:0] r2, input string tag);
    logic [5:0] a;
    en_n = 1'b0; req_n = r1;
    @(negedge clk);
    a = {code_n, grp_n, en_out_n};
    req_n = r2;
    @(negedge clk);
    checks++;
    if ({code_n, grp_n, en_out_n} !== a) begin
      fails++;
      $display("FAIL %s: got %b, expected %b", tag, {code_n, grp_n, en_out_n}, a);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    en_n = 1'b1; req_n = 16'hFFFF;
    @(posedge clk);
    apply(1'b1, 16'hFFFF, "R9 reset idle");
    apply(1'b1, 16'h0000, "R2 R9 disabled all requests");
    apply(1'b0, 16'hFFFF, "R4 R10 enabled no request");
    apply(1'b0, 16'hFFDF, "R1 request 5 alone");
    apply(1'b0, 16'hFFFE, "R1 R3 request 0 alone");
    apply(1'b0, 16'hFF7F, "R1 request 7 alone");
    apply(1'b0, 16'hFEFF, "R5 R7 request 8 alone");
    apply(1'b0, 16'hFDFF, "R5 request 9");
    apply(1'b0, 16'h7FFF, "R5 request 15");
    apply(1'b0, 16'h0000, "R5 R8 all requests");
    apply(1'b0, 16'hFF00, "R1 R3 lower half full");
    same_out(16'hEFFF, 16'hEF00, "R6 lower masked by request 12");
    same_out(16'hFEFF, 16'hFE5A, "R6 lower masked by request 8");
    for (int k = 0; k < 400; k++) begin
      logic [15:0] r;
      r = 16'($urandom);
      if (k % 3 == 0) r[15:8] = 8'hFF;
      apply(($urandom % 8) == 0, r, "R5 R7 R8 random");
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule